// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the per-channel sequencing engine of a DMA controller. It holds a source (read) address, a destination (write) address, a reload word that carries the transfer count and a run mode, and a small control word. Once the channel is started it issues one bus transfer in each cycle where it is busy and its data request input is high. After every issued transfer it moves both addresses. Each address has its own update rule: hold, step, double step or step backwards. The step is the transfer size in bytes. The block also counts the remaining transfers down.

The reload word keeps a 28-bit transfer count in bits 27:0 and a 4-bit run mode in bits 31:28. In normal mode the channel stops after its last transfer. In self-retrigger mode it reloads the count and keeps running. In endless mode the count never stops the channel. Writing the reload word through its trigger alias loads the count and starts the channel in one step. Writing the plain reload word loads the count only. The bus fabric, arbitration, the data path and interrupts sit outside this block.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, busy, xfer_valid, both addresses and the remaining count are all zero.
- R2: Configuration writes take effect at the clock edge on which cfg_we is high. cfg_sel 0 loads the read address, 1 loads the write address, 2 loads the reload word without starting the channel, 3 is the trigger alias of the reload word, and 4 loads the control word. Other select values change nothing.
- R3: A write through the trigger alias (cfg_sel 3) loads the remaining count from bits 27:0 of the data and sets busy, unless the count field is zero and the mode is not 0xF. In that case the channel stays idle and issues no transfer.
- R4: xfer_valid is high exactly when the channel is busy and dreq is high. During such a cycle xfer_rd_addr and xfer_wr_addr show the current addresses and xfer_size shows control bits 1:0.
- R5: Control bits 1:0 give the transfer size: 0 is a byte (step 1), 1 is a halfword (step 2), and 2 is a word (step 4). The value 3 is treated as a word.
- R6: After each transfer, the read address is updated by the type {ctrl[3], ctrl[2]} and the write address by {ctrl[5], ctrl[4]}. Type 0 holds the address, type 1 adds the step, type 2 adds twice the step, and type 3 subtracts the step. All arithmetic wraps modulo 2^32.
- R7: In normal mode (mode 0) each transfer decrements the remaining count by one. The transfer made while the count is 1 (or 0) sets the count to 0 and clears busy.
- R8: In self-retrigger mode (mode 1), the last transfer reloads the count from bits 27:0 of the last written reload word and busy stays set. The addresses continue from their current values.
- R9: In endless mode (mode 0xF), transfers leave the remaining count unchanged and never clear busy.
- R10: Mode values other than 0, 1 and 0xF behave exactly as normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| dreq | input | 1 | Data request from the paced peripheral |
| busy | output | 1 | Channel is running |
| xfer_valid | output | 1 | A bus transfer is issued this cycle |
| xfer_rd_addr | output | 32 | Current read address |
| xfer_wr_addr | output | 32 | Current write address |
| xfer_size | output | 2 | Transfer size code |
| remain | output | 28 | Remaining transfer count |

## Verification
xfer_valid follows busy and dreq in the same cycle with no register in the path. Address, count and busy updates, and every configuration write, show up one edge later. The bench drives dreq and the write strobe just after a falling edge and compares the combinational outputs before the next rising edge. It advances its own address, count and busy model at that rising edge and compares the registered results at the following falling edge. The address sequences for every update type at every size, including wraps across 2^32, and the self-retrigger, endless and zero-count cases are all checked in this way against bench functions.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 28,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dreq,
  output logic          busy,
  output logic          xfer_valid,
  output logic [AW-1:0] xfer_rd_addr,
  output logic [AW-1:0] xfer_wr_addr,
  output logic [1:0]    xfer_size,
  output logic [CW-1:0] remain
);
  localparam int RW = CW + MW;
  localparam logic [2:0] SEL_RD = 3'd0, SEL_WR = 3'd1, SEL_CNT = 3'd2,
                         SEL_TRIG = 3'd3, SEL_CTRL = 3'd4;
  localparam logic [MW-1:0] MODE_SELF = MW'(1);
  localparam logic [MW-1:0] MODE_ENDLESS = {MW{1'b1}};

  logic [AW-1:0] rd_q, wr_q;
  logic [RW-1:0] reload_q;
  logic [5:0]    ctrl_q;
  logic [CW-1:0] remain_q;
  logic          busy_q;

  wire [MW-1:0] mode    = reload_q[RW-1:CW];
  wire          endless = (mode == MODE_ENDLESS);
  wire          selftrig = (mode == MODE_SELF);
  wire [1:0]    size_eff = (ctrl_q[1:0] == 2'd3) ? 2'd2 : ctrl_q[1:0];
  wire [AW-1:0] step = AW'(1) << size_eff;
  wire [1:0]    rd_type = {ctrl_q[3], ctrl_q[2]};
  wire [1:0]    wr_type = {ctrl_q[5], ctrl_q[4]};
  wire          last = (remain_q <= CW'(1));
  wire [CW-1:0] trig_cnt = cfg_wdata[CW-1:0];
  wire [MW-1:0] trig_mode = cfg_wdata[RW-1:CW];

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input logic [1:0] t,
                                              input logic [AW-1:0] s);
    case (t)
      2'd0:    next_addr = a;
      2'd1:    next_addr = a + s;
      2'd2:    next_addr = a + (s << 1);
      default: next_addr = a - s;
    endcase
  endfunction

  assign busy         = busy_q;
  assign xfer_valid   = busy_q & dreq;
  assign xfer_rd_addr = rd_q;
  assign xfer_wr_addr = wr_q;
  assign xfer_size    = ctrl_q[1:0];
  assign remain       = remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      wr_q     <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      remain_q <= '0;
      busy_q   <= 1'b0;
    end else begin
      if (xfer_valid) begin
        rd_q <= next_addr(rd_q, rd_type, step);
        wr_q <= next_addr(wr_q, wr_type, step);
        if (!endless) begin
          if (last) begin
            if (selftrig) begin
              remain_q <= reload_q[CW-1:0];
              busy_q   <= |reload_q[CW-1:0];
            end else begin
              remain_q <= '0;
              busy_q   <= 1'b0;
            end
          end else begin
            remain_q <= remain_q - CW'(1);
          end
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_RD:   rd_q <= cfg_wdata;
          SEL_WR:   wr_q <= cfg_wdata;
          SEL_CNT: begin
            reload_q <= cfg_wdata[RW-1:0];
            remain_q <= trig_cnt;
          end
          SEL_TRIG: begin
            reload_q <= cfg_wdata[RW-1:0];
            remain_q <= trig_cnt;
            busy_q   <= (|trig_cnt) | (trig_mode == MODE_ENDLESS);
          end
          SEL_CTRL: ctrl_q <= cfg_wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !cfg_we && rd_type == 2'd0) |=> $stable(xfer_rd_addr)); // R6
  AST_WR_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !cfg_we && wr_type == 2'd3) |=> xfer_wr_addr == $past(xfer_wr_addr) - $past(step)); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !cfg_we && !endless && !last) |=> remain == $past(remain) - CW'(1)); // R7
  AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !cfg_we && !endless && !selftrig && last) |=> !busy); // R7
  AST_ENDLESS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && endless && !cfg_we) |=> (busy && $stable(remain))); // R9
  AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_TRIG && trig_cnt != '0) |=> busy); // R3
  AST_PLAIN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_CNT && !busy) |=> !busy); // R2
endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  logic clk = 0, rst_n = 0, cfg_we = 0, dreq = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic busy, xfer_valid;
  logic [31:0] xfer_rd_addr, xfer_wr_addr;
  logic [1:0] xfer_size;
  logic [27:0] remain;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_rd = 0, m_wr = 0, m_reload = 0;
  logic [5:0]  m_ctrl = 0;
  logic [27:0] m_remain = 0;
  logic        m_busy = 0;

  dma_chan_seq uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .busy(busy), .xfer_valid(xfer_valid),
    .xfer_rd_addr(xfer_rd_addr), .xfer_wr_addr(xfer_wr_addr), .xfer_size(xfer_size),
    .remain(remain));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stepsz(logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] a, logic [1:0] t, logic [1:0] s);
    case (t)
      2'd0: return a;
      2'd1: return a + stepsz(s);
      2'd2: return a + 2 * stepsz(s);
      default: return a - stepsz(s);
    endcase
  endfunction

  task automatic model_xfer();
    m_rd = nxt(m_rd, {m_ctrl[3], m_ctrl[2]}, m_ctrl[1:0]);
    m_wr = nxt(m_wr, {m_ctrl[5], m_ctrl[4]}, m_ctrl[1:0]);
    if (m_reload[31:28] != 4'hF) begin
      if (m_remain <= 1) begin
        if (m_reload[31:28] == 4'h1) begin
          m_remain = m_reload[27:0];
          m_busy = (m_reload[27:0] != 0);
        end else begin
          m_remain = 0;
          m_busy = 0;
        end
      end else m_remain = m_remain - 1;
    end
  endtask

  task automatic cfg(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    case (sel)
      3'd0: m_rd = d;
      3'd1: m_wr = d;
      3'd2: begin m_reload = d; m_remain = d[27:0]; end
      3'd3: begin m_reload = d; m_remain = d[27:0];
                  m_busy = (d[27:0] != 0) || (d[31:28] == 4'hF); end
      3'd4: m_ctrl = d[5:0];
      default: ;
    endcase
    #1 cfg_we = 0;
  endtask

  task automatic run(int cycles, int pct, string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      dreq = ($urandom % 100) < pct;
      #1;
      check({"R4 valid ", tag}, {31'd0, xfer_valid}, {31'd0, m_busy & dreq});
      check({"R6 rd ", tag}, xfer_rd_addr, m_rd);
      check({"R6 wr ", tag}, xfer_wr_addr, m_wr);
      check({"R7 busy ", tag}, {31'd0, busy}, {31'd0, m_busy});
      check({"R7 remain ", tag}, {4'd0, remain}, {4'd0, m_remain});
      check({"R5 size ", tag}, {30'd0, xfer_size}, {30'd0, m_ctrl[1:0]});
      @(posedge clk);
      if (m_busy && dreq) model_xfer();
    end
    @(negedge clk);
    dreq = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 valid", {31'd0, xfer_valid}, 0);
    check("R1 rd", xfer_rd_addr, 0);
    check("R1 wr", xfer_wr_addr, 0);
    check("R1 remain", {4'd0, remain}, 0);

    // R2: plain count write loads without starting; unused select ignored
    cfg(3'd2, 32'd7);
    #1 check("R2 plain no start", {31'd0, busy}, 0);
    check("R2 plain load", {4'd0, remain}, 7);
    cfg(3'd6, 32'hDEAD_BEEF);
    #1 check("R2 unused sel", xfer_rd_addr, 0);
    run(4, 100, "idle");

    // R5 R6 R7: every size (3 acts as word) and every update type
    for (int sz = 0; sz < 4; sz++) begin
      for (int rt = 0; rt < 4; rt++) begin
        int wt = (rt + sz + 1) % 4;
        cfg(3'd4, {26'd0, wt[1:0], rt[1:0], sz[1:0]});
        cfg(3'd0, (rt == 3) ? 32'h0000_0006 : 32'hFFFF_FFF4 + (($urandom % 4) << 2));
        cfg(3'd1, (wt == 3) ? 32'h0000_0003 : $urandom);
        cfg(3'd3, {4'h0, 28'd3 + 28'($urandom % 4)});
        run(16, 70, "seq");
        check("R7 done", {31'd0, busy}, 0);
      end
    end

    // R3: zero count trigger stays idle, no transfer
    cfg(3'd3, 32'h0000_0000);
    #1 check("R3 zero start", {31'd0, busy}, 0);
    run(4, 100, "R3 zero");

    // R8: self-retrigger keeps running, addresses continue
    cfg(3'd4, {26'd0, 2'd1, 2'd3, 2'd2});
    cfg(3'd3, {4'h1, 28'd3});
    run(10, 100, "R8 self");
    check("R8 still busy", {31'd0, busy}, 1);
    cfg(3'd2, 32'd1);
    run(4, 100, "R8 stop");
    check("R8 stopped", {31'd0, busy}, 0);

    // R9: endless never stops and never counts
    cfg(3'd3, 32'hFFFF_FFFF);
    run(25, 80, "R9 endless");
    check("R9 busy", {31'd0, busy}, 1);
    check("R9 remain", {4'd0, remain}, 28'hFFF_FFFF);
    cfg(3'd2, 32'd2);
    run(6, 100, "R9 stop");
    check("R9 stopped", {31'd0, busy}, 0);

    // R10: other modes act as normal
    cfg(3'd3, {4'h5, 28'd2});
    run(6, 100, "R10 mode5");
    check("R10 stopped", {31'd0, busy}, 0);
    cfg(3'd3, {4'h5, 28'd0});
    #1 check("R10 zero idle", {31'd0, busy}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule